// File: doc/BRIEF.md
# Last-Level Cache Maintenance Register Block

This block is the software-facing control and status front end of a shared last-level cache. A simple register bus (address, write enable, write data and combinational read data) reaches a read-only configuration word, a control word with the cache enable and an init-busy flag, one maintenance command register for each core, and the per-core completion status. Each core starts a whole-cache writeback-and-invalidate by writing a command code to its own command register. It then polls its own status field until that field reads zero.

A small sweep engine performs each accepted command by walking every set of the cache, one set per cycle. For each set it raises a writeback/invalidate strobe and presents the set index. Commands from different cores are queued and served one at a time. After reset, the engine first runs an initialisation sweep across all sets with a separate strobe. During that sweep the init-busy bit reads 1. A parameter selects one of two address layouts. The wide layout gives each core its own 4 KiB page. The compact layout packs the command registers 16 bytes apart and places every core's status in one shared word. The compact layout supports up to 4 cores and the wide layout up to 8.

Top module: `llcm_regblock`

## Requirements
- R1: The word at offset 0x0 reads bit 20 = 1 in the wide layout and 0 in the compact layout, with all other bits 0. Writes to it have no effect.
- R2: The control word at offset 0x8 stores every written bit except bit 14, and reads each one back unchanged. Bit 0 is the cache enable. A write with enable 0 followed by the same value with enable 1 leaves all other bits as written.
- R3: Control bit 14 is not writable. It reads 1 from reset until the initialisation sweep ends, and 0 from then on.
- R4: Starting in the first cycle after reset is released, the init strobe is high for exactly NUM_SETS cycles. During those cycles the set index steps 0, 1, …, NUM_SETS-1.
- R5: Writing exactly 0x12 to a core's command register queues a whole-cache writeback-and-invalidate for that core. The core's 4-bit status reads 1 while it waits and 2 while its sweep runs. The status returns to 0 in the cycle after its last set strobe.
- R6: A command sweep begins one cycle after its core is selected. It holds the writeback/invalidate strobe for NUM_SETS consecutive cycles, with the set index stepping 0 to NUM_SETS-1.
- R7: Only one sweep runs at a time. When the engine is idle, it selects the lowest-numbered core with a queued command. A waiting core keeps a status of 1 until its own sweep starts.
- R8: A write of any other code to a command register is ignored. A write of 0x12 while that core's previous command is still queued or running is also ignored. Neither write starts a sweep or changes the status.
- R9: In the wide layout, core n's command register is at 0x40 + n×0x1000, and its status is at 0x80 + n×0x1000 in bits [3:0].
- R10: In the compact layout, core n's command register is at 0x40 + n×0x10. Core n's status is in bits [4n+3:4n] of the single word at 0x80.
- R11: Reads of command registers and of any unmapped offset return 0. Writes to unmapped offsets change nothing.
- R12: The init strobe and the writeback/invalidate strobe are never high together. A command accepted during initialisation starts only after the init sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sweep_init | output | 1 | Per-set strobe of the initialisation sweep |
| sweep_wbinv | output | 1 | Per-set writeback/invalidate strobe of a command sweep |
| sweep_set | output | SET_W | Set index for the active strobe |

## Verification
A wrong queue bit shows at the ports in one of two ways. A command that is never served leaves the core's status stuck at 1. A dropped or extra command shows as a missing or extra burst of NUM_SETS strobes, visible within one sweep length. An arbitration fault shows immediately as the wrong core reading status 2 while strobes run, so the bench records the order of served cores from the status fields. A fault in the set counter or in the state sequencing is visible from the first out-of-order set index or the first overlap of the two strobes. The init-busy bit must fall in the cycle the init strobe drops.

// File: rtl/llcm_pkg.sv
// Package llcm_pkg
// Shared offsets, codes and types of the cache maintenance register block.
// Assumes a 16-bit byte-offset bus and 32-bit register words.
package llcm_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    localparam int OFS_CFG  = 'h00;
    localparam int OFS_CTRL = 'h08;
    localparam int OFS_CMD  = 'h40;
    localparam int OFS_STAT = 'h80;

    localparam int LAYOUT_BIT = 20;
    localparam int BUSY_BIT   = 14;

    localparam logic [DATA_W-1:0] CODE_WBINV_ALL = 32'h12;

    localparam logic [3:0] STAT_IDLE = 4'h0;
    localparam logic [3:0] STAT_WAIT = 4'h1;
    localparam logic [3:0] STAT_RUN  = 4'h2;

    typedef enum logic [1:0] {
        ENG_INIT = 2'd0,
        ENG_IDLE = 2'd1,
        ENG_RUN  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/llcm_decode.sv
// Module llcm_decode
// Turns a bus offset into hit lines for every register of the block.
// Assumes the compact layout holds at most 4 cores, so its command slots
// never overlap the status word. In the compact layout every core's status
// hit points at the same shared word.
module llcm_decode
    import llcm_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter bit LAYOUT_WIDE = 1'b0
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 cfg_hit,
    output logic                 ctrl_hit,
    output logic [NUM_CORES-1:0] cmd_hit,
    output logic [NUM_CORES-1:0] stat_hit
);
    localparam int CMD_STRIDE  = LAYOUT_WIDE ? 'h1000 : 'h10;
    localparam int STAT_STRIDE = LAYOUT_WIDE ? 'h1000 : 0;

    // Fixed single-word registers.
    assign cfg_hit  = (addr == ADDR_W'(OFS_CFG));
    assign ctrl_hit = (addr == ADDR_W'(OFS_CTRL));

    // Per-core slots, spaced by the layout's strides.
    for (genvar k = 0; k < NUM_CORES; k++) begin : g_slot
        assign cmd_hit[k]  = (addr == ADDR_W'(OFS_CMD + k * CMD_STRIDE));
        assign stat_hit[k] = (addr == ADDR_W'(OFS_STAT + k * STAT_STRIDE));
    end
endmodule

// File: rtl/llcm_engine.sv
// Module llcm_engine
// Holds the queue of accepted commands, picks the lowest queued core and
// walks all sets once per command. It also runs the initialisation sweep
// that follows reset. Assumes cmd_go pulses for one cycle per accepted write.
// If a core's sweep finishes in the same cycle that core writes a new
// command, the finish wins and the new command is dropped.
module llcm_engine
    import llcm_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_SETS  = 16,
    localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CORES-1:0]   cmd_go,
    output logic                   init_busy,
    output logic [4*NUM_CORES-1:0] status,
    output logic                   sweep_init,
    output logic                   sweep_wbinv,
    output logic [SET_W-1:0]       sweep_set
);
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

    eng_state_e           state;
    logic [SET_W-1:0]     cnt;
    logic [CORE_W-1:0]    active;
    logic [NUM_CORES-1:0] pending;
    logic [CORE_W-1:0]    pick;
    logic [NUM_CORES-1:0] done_mask;
    logic                 at_last;

    assign at_last = (cnt == LAST_SET);

    // Lowest-numbered queued core wins.
    always_comb begin
        pick = '0;
        for (int k = NUM_CORES - 1; k >= 0; k--) begin
            if (pending[k]) pick = CORE_W'(k);
        end
    end

    // Clears the queue bit of the core whose sweep ends this cycle.
    always_comb begin
        done_mask = '0;
        if (state == ENG_RUN && at_last) done_mask[active] = 1'b1;
    end

    // Sequencing of init, idle and command sweeps, plus the command queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ENG_INIT;
            cnt     <= '0;
            active  <= '0;
            pending <= '0;
        end else begin
            pending <= (pending | cmd_go) & ~done_mask;
            unique case (state)
                ENG_INIT: begin
                    cnt   <= at_last ? '0 : cnt + 1'b1;
                    state <= at_last ? ENG_IDLE : ENG_INIT;
                end
                ENG_IDLE: begin
                    cnt <= '0;
                    if (|pending) begin
                        state  <= ENG_RUN;
                        active <= pick;
                    end
                end
                ENG_RUN: begin
                    cnt   <= at_last ? '0 : cnt + 1'b1;
                    state <= at_last ? ENG_IDLE : ENG_RUN;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Per-core status code: idle, waiting or running.
    for (genvar k = 0; k < NUM_CORES; k++) begin : g_stat
        assign status[4*k +: 4] = !pending[k] ? STAT_IDLE :
                                  (state == ENG_RUN && active == CORE_W'(k)) ? STAT_RUN : STAT_WAIT;

        p_fall_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pending[k]) |-> $past(state == ENG_RUN && active == CORE_W'(k) && cnt == LAST_SET));

        p_rise_on_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending[k]) |-> $past(cmd_go[k]));

        p_lowest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ENG_IDLE && pending[k] && ((pending & NUM_CORES'((1 << k) - 1)) == '0))
            |=> (state == ENG_RUN && active == CORE_W'(k)));
    end

    assign init_busy   = (state == ENG_INIT);
    assign sweep_init  = (state == ENG_INIT);
    assign sweep_wbinv = (state == ENG_RUN);
    assign sweep_set   = cnt;

    p_set_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_RUN && $past(state) == ENG_RUN) |-> cnt == SET_W'($past(cnt) + 1'b1));

    p_init_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_busy) |-> $past(cnt) == LAST_SET);
endmodule

// File: rtl/llcm_regblock.sv
// Module llcm_regblock
// Register front end of the last-level cache maintenance logic: configuration
// word, control word, per-core command slots and status. Assumes NUM_CORES is
// at most 4 in the compact layout and at most 8 in the wide layout, and that
// NUM_SETS is at least 2.
module llcm_regblock
    import llcm_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int NUM_SETS    = 16,
    parameter bit LAYOUT_WIDE = 1'b0,
    localparam int SET_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sweep_init,
    output logic              sweep_wbinv,
    output logic [SET_W-1:0]  sweep_set
);
    localparam logic [DATA_W-1:0] CFG_WORD  = DATA_W'(LAYOUT_WIDE) << LAYOUT_BIT;
    localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BUSY_BIT;
    localparam int                PACK_STEP = LAYOUT_WIDE ? 0 : 4;

    logic                   cfg_hit, ctrl_hit;
    logic [NUM_CORES-1:0]   cmd_hit, stat_hit, cmd_go;
    logic                   init_busy;
    logic [4*NUM_CORES-1:0] status;
    logic [DATA_W-1:0]      ctrl_q;

    llcm_decode #(.NUM_CORES(NUM_CORES), .LAYOUT_WIDE(LAYOUT_WIDE)) u_decode (
        .addr     (bus_addr),
        .cfg_hit  (cfg_hit),
        .ctrl_hit (ctrl_hit),
        .cmd_hit  (cmd_hit),
        .stat_hit (stat_hit)
    );

    // A command slot accepts only the whole-cache writeback-and-invalidate code.
    assign cmd_go = (bus_we && bus_wdata == CODE_WBINV_ALL) ? cmd_hit : '0;

    llcm_engine #(.NUM_CORES(NUM_CORES), .NUM_SETS(NUM_SETS)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_go      (cmd_go),
        .init_busy   (init_busy),
        .status      (status),
        .sweep_init  (sweep_init),
        .sweep_wbinv (sweep_wbinv),
        .sweep_set   (sweep_set)
    );

    // Control word storage; the busy position is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctrl_q <= '0;
        else if (bus_we && ctrl_hit) ctrl_q <= bus_wdata & ~BUSY_MASK;
    end

    // Read mux: OR of every register that decodes at this offset.
    always_comb begin
        bus_rdata = '0;
        if (cfg_hit)  bus_rdata = bus_rdata | CFG_WORD;
        if (ctrl_hit) bus_rdata = bus_rdata | ctrl_q | (init_busy ? BUSY_MASK : '0);
        for (int k = 0; k < NUM_CORES; k++) begin
            if (stat_hit[k])
                bus_rdata = bus_rdata | (DATA_W'(status[4*k +: 4]) << (PACK_STEP * k));
        end
    end

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && ctrl_hit) |=> $stable(ctrl_q));

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(sweep_init && sweep_wbinv));
endmodule

// File: tb/llcm_regblock_tb.sv
// Directed bench: a compact-layout instance (u_dut) and a wide-layout
// instance share one bus; each scenario task checks its own results.
module llcm_regblock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS      = 8;
    localparam int SW         = $clog2(NSETS);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_n, rdata_w;
    logic        init_n, wbinv_n, init_w, wbinv_w;
    logic [SW-1:0] set_n, set_w;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    llcm_regblock #(.NUM_CORES(4), .NUM_SETS(NSETS), .LAYOUT_WIDE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
        .sweep_init(init_n), .sweep_wbinv(wbinv_n), .sweep_set(set_n));

    llcm_regblock #(.NUM_CORES(4), .NUM_SETS(NSETS), .LAYOUT_WIDE(1'b1)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_w),
        .sweep_init(init_w), .sweep_wbinv(wbinv_w), .sweep_set(set_w));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge after one write edge.
    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] n, output logic [31:0] w);
        bus_addr = a;
        #1;
        n = rdata_n; w = rdata_w;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_init();
        repeat (NSETS + 2) @(negedge clk);
    endtask

    task automatic count_wbinv(input int cycles, output int cnt_n, output int cnt_w);
        cnt_n = 0; cnt_w = 0;
        for (int i = 0; i < cycles; i++) begin
            if (wbinv_n) cnt_n++;
            if (wbinv_w) cnt_w++;
            @(negedge clk);
        end
    endtask

    // R3 R4 R1 R5: reset state and the initialisation sweep.
    task automatic t_init();
        logic [31:0] n, w;
        do_reset();
        rd(16'h0, n, w);
        chk("R1 compact cfg", n, 32'h0);
        chk("R1 wide cfg", w, 32'h0010_0000);
        rd(16'h80, n, w);
        chk("R5 status after reset", n, 32'h0);
        for (int i = 0; i < NSETS; i++) begin
            chk("R4 init strobe", {31'b0, init_n}, 32'h1);
            chk("R4 init set", 32'(set_n), 32'(i));
            chk("R12 no wbinv in init", {31'b0, wbinv_n}, 32'h0);
            rd(16'h8, n, w);
            chk("R3 busy during init", n & 32'h4000, 32'h4000);
            @(negedge clk);
        end
        chk("R4 init strobe ends", {31'b0, init_n}, 32'h0);
        rd(16'h8, n, w);
        chk("R3 busy clear", n, 32'h0);
    endtask

    // R2 R3 R1: control word round trip and read-only fields.
    task automatic t_ctrl();
        logic [31:0] n, w;
        wr(16'h8, 32'h00F0_4AF0);
        rd(16'h8, n, w);
        chk("R2 ctrl step1 enable 0", n, 32'h00F0_0AF0);
        wr(16'h8, 32'h00F0_4AF1);
        rd(16'h8, n, w);
        chk("R2 ctrl step2 enable 1", n, 32'h00F0_0AF1);
        chk("R3 bit14 not writable", n & 32'h4000, 32'h0);
        wr(16'h0, 32'hFFFF_FFFF);
        rd(16'h0, n, w);
        chk("R1 compact cfg write ignored", n, 32'h0);
        chk("R1 wide cfg write ignored", w, 32'h0010_0000);
    endtask

    // R5 R6 R10: compact layout, one command from core 1.
    task automatic t_flush_compact();
        logic [31:0] n, w;
        wr(16'h50, 32'h12);
        rd(16'h80, n, w);
        chk("R10 core1 waiting field", n, 32'h10);
        @(negedge clk);
        for (int j = 0; j < NSETS; j++) begin
            chk("R6 wbinv strobe", {31'b0, wbinv_n}, 32'h1);
            chk("R6 wbinv set", 32'(set_n), 32'(j));
            rd(16'h80, n, w);
            chk("R5 core1 running", n, 32'h20);
            @(negedge clk);
        end
        chk("R6 strobe ends", {31'b0, wbinv_n}, 32'h0);
        rd(16'h80, n, w);
        chk("R5 status back to 0", n, 32'h0);
        chk("R11 wide ignores compact slot", {31'b0, wbinv_w}, 32'h0);
    endtask

    // R8: bad code and duplicate command are ignored.
    task automatic t_ignore();
        logic [31:0] n, w;
        int cn, cw;
        wr(16'h40, 32'h13);
        rd(16'h80, n, w);
        chk("R8 bad code status", n, 32'h0);
        count_wbinv(12, cn, cw);
        chk("R8 bad code no sweep", 32'(cn), 32'h0);
        wr(16'h40, 32'h12);
        wr(16'h40, 32'h12);
        count_wbinv(3 * NSETS, cn, cw);
        chk("R8 duplicate gives one sweep", 32'(cn), 32'(NSETS));
        rd(16'h80, n, w);
        chk("R8 status idle after", n, 32'h0);
    endtask

    // R7: priority and waiting status.
    task automatic t_priority();
        logic [31:0] n, w;
        int ord[3];
        int seen = 0;
        int last = -1;
        int cur;
        logic [31:0] wait_seen = 32'hFFFF_FFFF;
        wr(16'h70, 32'h12);
        wr(16'h60, 32'h12);
        wr(16'h50, 32'h12);
        for (int c = 0; c < 5 * NSETS; c++) begin
            rd(16'h80, n, w);
            if (wbinv_n) begin
                cur = -1;
                for (int k = 0; k < 4; k++) if (((n >> (4 * k)) & 32'hF) == 32'h2) cur = k;
                if (cur != last) begin
                    if (seen < 3) ord[seen] = cur;
                    seen++;
                    last = cur;
                    if (cur == 1) wait_seen = (n >> 8) & 32'hF;
                end
            end
            @(negedge clk);
        end
        chk("R7 sweep count", 32'(seen), 32'h3);
        chk("R7 first core", 32'(ord[0]), 32'h3);
        chk("R7 second core lowest", 32'(ord[1]), 32'h1);
        chk("R7 third core", 32'(ord[2]), 32'h2);
        chk("R7 core2 waits nonzero", wait_seen, 32'h1);
    endtask

    // R9 R11: wide layout slots and unmapped reads.
    task automatic t_wide();
        logic [31:0] n, w;
        int cn, cw;
        wr(16'h1040, 32'h12);
        rd(16'h1080, n, w);
        chk("R9 wide core1 waiting", w, 32'h1);
        chk("R11 compact unmapped read", n, 32'h0);
        rd(16'h80, n, w);
        chk("R9 wide core0 idle", w, 32'h0);
        @(negedge clk);
        rd(16'h1080, n, w);
        chk("R9 wide core1 running", w, 32'h2);
        count_wbinv(2 * NSETS, cn, cw);
        chk("R9 wide sweep length", 32'(cw), 32'(NSETS));
        chk("R11 compact no sweep", 32'(cn), 32'h0);
        rd(16'h1080, n, w);
        chk("R9 wide core1 done", w, 32'h0);
        rd(16'h40, n, w);
        chk("R11 cmd reads 0", n, 32'h0);
        rd(16'h44, n, w);
        chk("R11 unmapped compact", n, 32'h0);
        rd(16'h2000, n, w);
        chk("R11 unmapped wide", w, 32'h0);
    endtask

    // R12: command accepted during init waits for init to end.
    task automatic t_cmd_in_init();
        int cn, cw;
        int ov = 0;
        do_reset();
        wr(16'h40, 32'h12);
        while (init_n) begin
            if (wbinv_n) ov++;
            @(negedge clk);
        end
        chk("R12 no overlap with init", 32'(ov), 32'h0);
        count_wbinv(2 * NSETS, cn, cw);
        chk("R12 queued sweep after init", 32'(cn), 32'(NSETS));
    endtask

    initial begin
        @(negedge clk);
        t_init();
        t_ctrl();
        t_flush_compact();
        t_ignore();
        t_priority();
        t_wide();
        t_cmd_in_init();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule